// File: doc/BRIEF.md
# SPI Status Poller With Timeout

This block polls a target device over SPI until that device reports a completion state, reports an interface fault, or takes too long. A start pulse latches a caller-supplied mask of required status bits. The block then reads the target's status byte over and over, with no pause except a short chip-select gap, until one of three outcomes occurs. When it ends, it raises a one-cycle done pulse together with exactly one verdict flag and the last status byte it sampled.

Each status sample is made of two identical one-byte SPI transactions, each sending the read-status opcode 0x00. Chip-select is released between the two transactions. The first returned byte can be stale, so the block discards it and keeps only the byte from the second transaction. The bus runs in SPI mode 0 with the most significant bit first. The serial clock period is set by a parameter, and so are the length of the gap and the timeout.

Top module: `spi_status_poller`

## Requirements
- R1: During and after reset, cs_n_o is high, sclk_o is low, mosi_o is low, and busy_o, done_o, pass_o, err_o and tmo_o are low. status_o is 0x00.
- R2: start_i is accepted only while busy_o is low, and mask_i is captured at that moment. A start_i pulse while busy does not change the mask in use and does not restart the poll.
- R3: Each status sample is two single-byte mode-0 transactions. The clock idles low. miso_i is read before each rising edge, most significant bit first. mosi_o carries opcode 0x00. cs_n_o stays high for GAP_CYC cycles between transactions.
- R4: Only the byte from the second transaction of a sample is evaluated. The byte from the first transaction never affects the result.
- R5: If bit 2 (interface violation) or bit 3 (interface error) of the sample is set, polling ends with err_o. This takes priority over success.
- R6: Polling ends with pass_o when (sample AND (mask OR 0x01)) equals the mask. That is, bit 0 (busy) is clear and every mask bit is set.
- R7: The elapsed-cycle count since start is compared with TIMEOUT_CYC only after a sample has been evaluated without a verdict. If the count has reached the limit, polling ends with tmo_o. Otherwise the next sample follows immediately after the gap.
- R8: At the end, done_o pulses for one cycle and exactly one of pass_o, err_o and tmo_o is set. busy_o falls in the same cycle.
- R9: status_o and the verdict flags hold their final values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a poll (accepted when idle) |
| mask_i | input | 8 | Required status bits |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict: completion condition met |
| err_o | output | 1 | Verdict: fault bit seen |
| tmo_o | output | 1 | Verdict: timeout |
| status_o | output | 8 | Last evaluated status byte |
| cs_n_o | output | 1 | SPI chip-select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to target |
| miso_i | input | 1 | SPI data from target |

## Verification
The bench's target model returns 0xFF as the first byte of every sample and the scripted byte as the second. If the transaction-pair tracking went wrong, the discarded byte would be evaluated, and the ports would show an error verdict and status 0xFF on the very first sample. A mask that is not held, or that is captured while busy, shows up as a verdict on the wrong sample, so the count of transactions at done differs from the expected count. A timeout counter that is off, or checked too early or too late, changes the exact number of samples before tmo_o rises.

// File: rtl/spi_status_poller.sv
module spi_status_poller #(
  parameter int HALF_DIV    = 4,
  parameter int GAP_CYC     = 2,
  parameter int TIMEOUT_CYC = 100000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] mask_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       pass_o,
  output logic       err_o,
  output logic       tmo_o,
  output logic [7:0] status_o,
  output logic       cs_n_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int TW = $clog2(TIMEOUT_CYC + 1) + 1;
  localparam logic [7:0] RD_OP = 8'h00;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t           st;
  logic [DW-1:0] div;
  logic [3:0]    ph;
  logic          second;
  logic [GW-1:0] gcnt;
  logic [7:0]    rx, mask_q;
  logic [TW-1:0] tcnt;

  wire half_end = (div == DW'(HALF_DIV - 1));
  wire hit_err  = rx[2] | rx[3];
  wire hit_pass = ((rx & (mask_q | 8'h01)) == mask_q);
  wire hit_tmo  = (tcnt >= TW'(TIMEOUT_CYC));
  wire [TW-1:0] tcnt_nx = hit_tmo ? tcnt : tcnt + 1'b1;

  assign busy_o = (st != S_IDLE);
  assign cs_n_o = (st != S_XFER);
  assign sclk_o = (st == S_XFER) & ph[0];
  assign mosi_o = (st == S_XFER) & RD_OP[3'd7 - ph[3:1]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div      <= '0;
      ph       <= '0;
      second   <= 1'b0;
      gcnt     <= '0;
      rx       <= '0;
      mask_q   <= '0;
      tcnt     <= '0;
      done_o   <= 1'b0;
      pass_o   <= 1'b0;
      err_o    <= 1'b0;
      tmo_o    <= 1'b0;
      status_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            mask_q <= mask_i;
            pass_o <= 1'b0;
            err_o  <= 1'b0;
            tmo_o  <= 1'b0;
            tcnt   <= '0;
            second <= 1'b0;
            div    <= '0;
            ph     <= '0;
            st     <= S_XFER;
          end
        end
        S_XFER: begin
          tcnt <= tcnt_nx;
          div  <= half_end ? '0 : div + 1'b1;
          if (half_end) begin
            ph <= ph + 1'b1;
            if (!ph[0]) rx <= {rx[6:0], miso_i};
            if (ph == 4'd15) begin
              gcnt <= '0;
              if (!second) begin
                second <= 1'b1;
                st     <= S_GAP;
              end else begin
                second   <= 1'b0;
                status_o <= rx;
                if (hit_err) begin
                  err_o  <= 1'b1;
                  done_o <= 1'b1;
                  st     <= S_IDLE;
                end else if (hit_pass) begin
                  pass_o <= 1'b1;
                  done_o <= 1'b1;
                  st     <= S_IDLE;
                end else if (hit_tmo) begin
                  tmo_o  <= 1'b1;
                  done_o <= 1'b1;
                  st     <= S_IDLE;
                end else begin
                  st <= S_GAP;
                end
              end
            end
          end
        end
        S_GAP: begin
          tcnt <= tcnt_nx;
          gcnt <= gcnt + 1'b1;
          if (gcnt == GW'(GAP_CYC - 1)) begin
            div <= '0;
            ph  <= '0;
            st  <= S_XFER;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_status_poller_chk.sv
module spi_status_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic       err_o,
  input logic       tmo_o,
  input logic [7:0] status_o,
  input logic       cs_n_o,
  input logic       sclk_o,
  input logic       mosi_o
);
  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n_o |-> !sclk_o); // R3
  AST_OPCODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !cs_n_o |-> !mosi_o); // R3
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ($countones({pass_o, err_o, tmo_o}) == 1)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (!busy_o && cs_n_o)); // R8
  AST_ERR_HAS_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (done_o && err_o) |-> (status_o[2] || status_o[3])); // R5
  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !err_o) |-> !(status_o[2] || status_o[3])); // R5
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && !$past(busy_o) && !$past(start_i)) |-> ($stable(status_o) && $stable({pass_o, err_o, tmo_o}))); // R9
endmodule

bind spi_status_poller spi_status_poller_chk chk_i (.*);

// File: tb/spi_status_poller_tb_top.sv
module spi_status_poller_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mask = '0;
  logic busy, done, pass, err, tmo, cs_n, sclk, mosi, miso;
  logic [7:0] status;

  int errors = 0;
  int checks = 0;
  int txn = 0;
  int mosi_bad = 0;
  int cyc = 0;
  logic [7:0] script [3];
  logic [7:0] sh = 8'h00;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_status_poller #(.HALF_DIV(2), .GAP_CYC(2), .TIMEOUT_CYC(300)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(mask),
    .busy_o(busy), .done_o(done), .pass_o(pass), .err_o(err), .tmo_o(tmo),
    .status_o(status), .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
  );

  always @(negedge cs_n) begin
    txn = txn + 1;
    if (txn % 2 == 1) sh = 8'hFF;
    else sh = script[(txn / 2 - 1) > 2 ? 2 : (txn / 2 - 1)];
  end
  always @(negedge sclk) if (!cs_n) sh = {sh[6:0], 1'b0};
  always @(posedge sclk) if (mosi) mosi_bad = mosi_bad + 1;
  assign miso = sh[7];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] m, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, output bit ok);
    int n;
    script[0] = a; script[1] = b; script[2] = c;
    txn = 0;
    @(negedge clk); mask = m; start = 1'b1;
    @(negedge clk); start = 1'b0; mask = 8'h00;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    ok = done;
  endtask

  // mask, s0, s1, s2, status, verdict(1 pass 2 err 3 tmo), pairs
  localparam logic [45:0] VEC [8] = '{
    {8'h02, 8'h03, 8'h02, 8'h02, 8'h02, 2'd1, 4'd2},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1, 4'd1},
    {8'h02, 8'h01, 8'h05, 8'h05, 8'h05, 2'd2, 4'd2},
    {8'h00, 8'h09, 8'h09, 8'h09, 8'h09, 2'd2, 4'd1},
    {8'h02, 8'h06, 8'h06, 8'h06, 8'h06, 2'd2, 4'd1},
    {8'h12, 8'h02, 8'h12, 8'h12, 8'h12, 2'd1, 4'd2},
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 2'd3, 4'd5},
    {8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 2'd3, 4'd5}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    logic [1:0] v;
    script[0] = 8'h00; script[1] = 8'h00; script[2] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({cs_n, sclk, mosi, busy, done, pass, err, tmo} == 8'b1000_0000, "R1", {cs_n, sclk, mosi, busy, done, pass, err, tmo}, 8'h80);
    chk(status == 8'h00, "R1 status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy && !done, "R1 after release", {cs_n, busy, done}, 3'b100);

    for (int i = 0; i < 8; i++) begin
      run(VEC[i][45:38], VEC[i][37:30], VEC[i][29:22], VEC[i][21:14], ok);
      chk(ok, "R8 done seen", ok, 1);
      v = pass ? 2'd1 : err ? 2'd2 : tmo ? 2'd3 : 2'd0;
      // R4 R5 R6 R7 verdict and status
      chk(v == VEC[i][5:4], (VEC[i][5:4] == 2'd1) ? "R6 verdict" : (VEC[i][5:4] == 2'd2) ? "R5 verdict" : "R7 verdict", v, VEC[i][5:4]);
      chk(status == VEC[i][13:6], "R4 status byte", status, VEC[i][13:6]);
      chk(txn == 2 * VEC[i][3:0], "R3 R7 transaction count", txn, 2 * VEC[i][3:0]);
      chk($countones({pass, err, tmo}) == 1 && !busy, "R8 one verdict", {pass, err, tmo}, 1);
      @(negedge clk);
      chk(!done, "R8 done pulse width", done, 0);
      repeat (20) @(negedge clk);
      chk(status == VEC[i][13:6] && v == (pass ? 2'd1 : err ? 2'd2 : tmo ? 2'd3 : 2'd0), "R9 held", status, VEC[i][13:6]);
    end

    // R2 start while busy ignored: mask 0x00 would pass on the first sample
    script[0] = 8'h00; script[1] = 8'h02; script[2] = 8'h02;
    txn = 0;
    @(negedge clk); mask = 8'h02; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    mask = 8'h00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
    chk(pass && status == 8'h02, "R2 pass with captured mask", status, 8'h02);
    chk(txn == 4, "R2 no restart by busy start", txn, 4);

    chk(mosi_bad == 0, "R3 opcode 0x00 on mosi", mosi_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule